// File: doc/BRIEF.md
# Unaligned Word Load/Store Merge Unit

This block forms the result of the four partial-word memory instructions, which move the bytes of a misaligned 32-bit word between memory and a register in two steps. It takes the low two bits of the effective address (the byte offset), the aligned memory word that holds the addressed bytes, the register operand and a 2-bit operation code. For the two load forms it returns the register value after merging. For the two store forms it returns the memory word after merging, with one byte-enable bit per lane that marks the lanes now holding register bytes.

Each operation shifts one operand by a whole number of bytes that depends on the offset. The shifted bytes replace some lanes of the other operand, and the remaining lanes pass through unchanged. A fixed byte order is used, with lane i holding bits [8i+7:8i]. All outputs are registered, so a result appears one clock after its inputs are presented. Address generation and the memory port sit outside this block.

Top module: `uamerge_unit`

## Requirements
- R1: While rst_n is low, load_o, store_o and be_o are all zero.
- R2: Inputs present at a rising clock edge set the outputs from that edge onward. op_i encoding: 0 = load-left, 1 = load-right, 2 = store-left, 3 = store-right. k is off_i and s is a bit count.
- R3: Load-left, with s = 24 - 8k: load_o = (mem_i << s) OR (reg_i AND low-s-bit mask). At k = 3 the result is mem_i.
- R4: Load-right, with s = 8k: load_o = (mem_i >> s) OR (the top s bits of reg_i kept in place). At k = 0 the result is mem_i with no reg_i bits.
- R5: Store-left, with s = 24 - 8k: store_o = (reg_i >> s) OR (the top s bits of mem_i kept in place).
- R6: Store-right, with s = 8k: store_o = (reg_i << s) OR (mem_i AND low-s-bit mask).
- R7: For a store, be_o bit i is 1 exactly when lane i of store_o comes from reg_i. For store-left these are lanes 0..k. For store-right these are lanes k..3.
- R8: Store-left at k = 3 and store-right at k = 0 give be_o = 4'b1111 and store_o = reg_i.
- R9: For a load, be_o = 0 and store_o = mem_i. For a store, load_o = reg_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation code (see R2) |
| off_i | input | 2 | Byte offset of the effective address |
| mem_i | input | 32 | Aligned memory word |
| reg_i | input | 32 | Register operand |
| load_o | output | 32 | Merged register value |
| store_o | output | 32 | Merged memory word |
| be_o | output | 4 | Store byte-enable, one bit per lane |

## Verification
On every clock, the assertions check the following against the inputs of the previous cycle:
- the number of enabled lanes and the anchored end lane for both store forms;
- the full-word cases;
- the pass-through outputs of the inactive direction;
- the two offsets at which a load returns the memory word unchanged.

The byte arrangement of every partially merged word, at each offset and with distinct byte patterns, is shown only by the bench. The bench compares every output against a model built from the shift-and-mask formulas.

// File: rtl/uamerge_pkg.sv
package uamerge_pkg;

    typedef enum logic [1:0] {
        UA_LD_LEFT  = 2'd0,
        UA_LD_RIGHT = 2'd1,
        UA_ST_LEFT  = 2'd2,
        UA_ST_RIGHT = 2'd3
    } ua_op_e;

    // Stores carry the register into memory.
    function automatic logic op_is_store(input ua_op_e op);
        return op[1];
    endfunction

    // Left forms count their shift down from the top lane.
    function automatic logic op_is_left(input ua_op_e op);
        return ~op[0];
    endfunction

endpackage

// File: rtl/uamerge_lane_sel.sv
module uamerge_lane_sel
    import uamerge_pkg::*;
#(
    parameter int unsigned NB = 4,
    localparam int unsigned OFFW = $clog2(NB)
) (
    input  logic [1:0]      op,
    input  logic [OFFW-1:0] off,
    output logic [NB-1:0]   take
);

    localparam int LAST = int'(NB) - 1;

    ua_op_e kind;
    assign kind = ua_op_e'(op);

    // One bit per lane: 1 when the lane receives the shifted operand.
    always_comb begin
        int k;
        k = int'(off);
        for (int j = 0; j < int'(NB); j++) begin
            unique case (kind)
                UA_LD_LEFT:  take[j] = (j + k) >= LAST;
                UA_LD_RIGHT: take[j] = (j + k) <= LAST;
                UA_ST_LEFT:  take[j] = j <= k;
                default:     take[j] = j >= k;
            endcase
        end
    end

endmodule

// File: rtl/uamerge_shifter.sv
module uamerge_shifter
    import uamerge_pkg::*;
#(
    parameter int unsigned NB = 4,
    parameter int unsigned BW = 8,
    localparam int unsigned OFFW = $clog2(NB),
    localparam int unsigned W = NB * BW
) (
    input  logic [1:0]      op,
    input  logic [OFFW-1:0] off,
    input  logic [W-1:0]    mem,
    input  logic [W-1:0]    regv,
    output logic [W-1:0]    shifted
);

    localparam int LAST = int'(NB) - 1;

    ua_op_e kind;
    assign kind = ua_op_e'(op);

    always_comb begin
        int          nbytes;
        logic [W-1:0] src;
        logic        up;
        nbytes  = op_is_left(kind) ? (LAST - int'(off)) : int'(off);
        src     = op_is_store(kind) ? regv : mem;
        up      = (kind == UA_LD_LEFT) || (kind == UA_ST_RIGHT);
        shifted = up ? (src << (nbytes * int'(BW)))
                     : (src >> (nbytes * int'(BW)));
    end

endmodule

// File: rtl/uamerge_unit.sv
module uamerge_unit
    import uamerge_pkg::*;
#(
    parameter int unsigned NB = 4,
    parameter int unsigned BW = 8,
    localparam int unsigned OFFW = $clog2(NB),
    localparam int unsigned W = NB * BW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      op_i,
    input  logic [OFFW-1:0] off_i,
    input  logic [W-1:0]    mem_i,
    input  logic [W-1:0]    reg_i,
    output logic [W-1:0]    load_o,
    output logic [W-1:0]    store_o,
    output logic [NB-1:0]   be_o
);

    typedef struct packed {
        logic [W-1:0]  ld;
        logic [W-1:0]  st;
        logic [NB-1:0] be;
    } ua_out_t;

    ua_out_t       out_d, out_q;
    logic [NB-1:0] take;
    logic [W-1:0]  shifted;

    uamerge_lane_sel #(.NB(NB)) u_sel (
        .op   (op_i),
        .off  (off_i),
        .take (take)
    );

    uamerge_shifter #(.NB(NB), .BW(BW)) u_shift (
        .op      (op_i),
        .off     (off_i),
        .mem     (mem_i),
        .regv    (reg_i),
        .shifted (shifted)
    );

    always_comb begin
        logic         store;
        logic [W-1:0] base;
        logic [W-1:0] merged;
        store = op_is_store(ua_op_e'(op_i));
        base  = store ? mem_i : reg_i;
        for (int j = 0; j < int'(NB); j++) begin
            merged[j*BW +: BW] = take[j] ? shifted[j*BW +: BW] : base[j*BW +: BW];
        end
        out_d.ld = store ? reg_i : merged;
        out_d.st = store ? merged : mem_i;
        out_d.be = store ? take : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign load_o  = out_q.ld;
    assign store_o = out_q.st;
    assign be_o    = out_q.be;

endmodule

// File: rtl/uamerge_chk.sv
module uamerge_chk #(
    parameter int unsigned NB = 4,
    parameter int unsigned BW = 8,
    localparam int unsigned OFFW = $clog2(NB),
    localparam int unsigned W = NB * BW
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      op_i,
    input logic [OFFW-1:0] off_i,
    input logic [W-1:0]    mem_i,
    input logic [W-1:0]    reg_i,
    input logic [W-1:0]    load_o,
    input logic [W-1:0]    store_o,
    input logic [NB-1:0]   be_o
);

    logic primed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    a_r9_load_side: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !$past(op_i[1]) |-> (be_o == '0) && (store_o == $past(mem_i)));

    a_r9_store_side: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i[1]) |-> load_o == $past(reg_i));

    a_r7_left_count: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(op_i) == 2'd2) |->
            ($countones(be_o) == int'($past(off_i)) + 1) && be_o[0]);

    a_r7_right_count: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(op_i) == 2'd3) |->
            ($countones(be_o) == int'(NB) - int'($past(off_i))) && be_o[NB-1]);

    a_r8_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i[1]) && (&be_o) |-> store_o == $past(reg_i));

    a_r4_right_zero: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(op_i) == 2'd1) && ($past(off_i) == '0) |->
            load_o == $past(mem_i));

    a_r3_left_top: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(op_i) == 2'd0) && ($past(off_i) == OFFW'(NB - 1)) |->
            load_o == $past(mem_i));

endmodule

bind uamerge_unit uamerge_chk #(.NB(NB), .BW(BW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .off_i   (off_i),
    .mem_i   (mem_i),
    .reg_i   (reg_i),
    .load_o  (load_o),
    .store_o (store_o),
    .be_o    (be_o)
);

// File: tb/tb_uamerge_unit.sv
module tb_uamerge_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = '0;
    logic [1:0]  off_i = '0;
    logic [31:0] mem_i = '0;
    logic [31:0] reg_i = '0;
    logic [31:0] load_o, store_o;
    logic [3:0]  be_o;

    int checks = 0;
    int fails  = 0;

    logic [31:0] q_ld[$];
    logic [31:0] q_st[$];
    logic [3:0]  q_be[$];
    string       q_tag[$];

    uamerge_unit dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .off_i(off_i),
        .mem_i(mem_i), .reg_i(reg_i),
        .load_o(load_o), .store_o(store_o), .be_o(be_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] lowmask(int n);
        if (n <= 0) return 32'h0;
        return 32'hFFFF_FFFF >> (32 - n);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one vector on a falling edge; compare the one driven a cycle earlier.
    task automatic step(int op, int k, logic [31:0] m, logic [31:0] r);
        logic [31:0] eld, est;
        logic [3:0]  ebe;
        string       tag;
        int          s;
        @(negedge clk);
        if (q_ld.size() > 0) begin
            string t;
            t = q_tag.pop_front();
            check({t, " R2 load_o"},  load_o,        q_ld.pop_front());
            check({t, " R2 store_o"}, store_o,       q_st.pop_front());
            check({t, " R7 be_o"},    {28'h0, be_o}, {28'h0, q_be.pop_front()});
        end
        eld = r; est = m; ebe = 4'h0;
        case (op)
            0: begin s = 24 - 8*k; eld = (m << s) | (r & lowmask(s));
                     tag = (k == 3) ? "R3 ll-full" : "R3 ll"; end
            1: begin s = 8*k; eld = (m >> s) | (s == 0 ? 32'h0 : (r & (lowmask(s) << (32 - s))));
                     tag = (k == 0) ? "R4 lr-zero" : "R4 lr"; end
            2: begin s = 24 - 8*k; est = (r >> s) | (s == 0 ? 32'h0 : (m & (lowmask(s) << (32 - s))));
                     ebe = 4'((1 << (k + 1)) - 1);
                     tag = (k == 3) ? "R8 sl-full" : "R5 sl"; end
            default: begin s = 8*k; est = (r << s) | (m & lowmask(s));
                     ebe = 4'((4'hF << k) & 4'hF);
                     tag = (k == 0) ? "R8 sr-full" : "R6 sr"; end
        endcase
        if (op >= 2) tag = {tag, " R9"};
        else         tag = {tag, " R9"};
        op_i = 2'(op); off_i = 2'(k); mem_i = m; reg_i = r;
        q_ld.push_back(eld); q_st.push_back(est); q_be.push_back(ebe); q_tag.push_back(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        mem_i = 32'hDEAD_BEEF; reg_i = 32'h1234_5678; op_i = 2'd3;
        @(posedge clk); #1;
        check("R1 reset load_o",  load_o,        32'h0);
        check("R1 reset store_o", store_o,       32'h0);
        check("R1 reset be_o",    {28'h0, be_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int op = 0; op < 4; op++)
            for (int k = 0; k < 4; k++) begin
                step(op, k, 32'hA1B2_C3D4, 32'h1526_3748);
                step(op, k, 32'hFFFF_FFFF, 32'h0000_0000);
                step(op, k, 32'h0000_0000, 32'hFFFF_FFFF);
            end
        for (int i = 0; i < 400; i++)
            step(int'($urandom_range(3)), int'($urandom_range(3)), $urandom, $urandom);
        step(0, 0, 32'h0, 32'h0);
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule